// File: doc/BRIEF.md
# Error-Corrected Source-Route Lookup Table

This block turns the upper bits of a transaction address into a source-routing path for a network interface. A fixed array of comparators places the address tag in one of a set of hard-coded address regions. The number of the matching region picks one path register, and that register's contents go out with the response in the following cycle. Paths are written at boot, or after the topology changes, through a single write port. Every write passes through one shared single-error-correcting, double-error-detecting encoder with odd-weight columns. Every read passes through one shared decoder.

Each entry has a status bit. When the bit is clear, the entry is served by its own primary register. When it is set, the entry is served by a spare register, and the spare is chosen by the low bits of the entry number. A small repair state machine handles single-bit errors. It has four states:
- IDLE: accepts lookups and writes.
- WBACK: rewrites the corrected word into the entry.
- RECHK: reads the entry again through the shared decoder.
- REMAP: sets the status bit and copies the corrected word into the spare.

The transitions are:
- IDLE to WBACK on a lookup hit that shows a single error.
- WBACK to RECHK always.
- RECHK to REMAP when a single error is still seen in a primary register.
- RECHK to IDLE otherwise.
- REMAP to IDLE always.

A fault-emulation mask input is XORed onto every primary-register read. It models defective cells, so that both transient and permanent behaviour can be exercised.

Top module: `route_lut`

## Requirements
- R1: The tag is `lk_addr[ADDR_W-1 -: TAG_W]`. Entry i hits when i*REGION_STEP <= tag < (i+1)*REGION_STEP, for i < N_ENTRY. With the defaults there are 8 regions of 16 tag values each, and a tag of 128 or more misses. `err_idx` reports the matched entry.
- R2: `rsp_valid` is high in the cycle after a lookup is accepted (`lk_valid` while `lk_ready`), and low after any cycle with no accepted lookup.
- R3: On a miss, `rsp_hit` is 0, `rsp_path` is 0, `err_type` is 00, `err_idx` is 0 and `err_spare` is 0.
- R4: A path written through the write port is returned unchanged by a later lookup of that entry, with `err_type` 00 (code 00 means no error).
- R5: A single flipped bit in the stored codeword gives `err_type` 01 and the corrected path. In the codeword the path occupies bits [PATH_W-1:0] and the check bits sit above it.
- R6: Two flipped bits give `err_type` 10 and `rsp_path` 0, and start no repair. Code 11 never appears.
- R7: After a response with `err_type` 01, `lk_ready` is low for two cycles (WBACK, RECHK). If the rewrite cleared the error, it returns high and the entry stays on its primary register (`err_spare` 0).
- R8: If the error is still present at RECHK on a primary register, a third busy cycle (REMAP) follows. From then on the entry is served by its spare: `err_spare` 1, `err_type` 00, corrected path.
- R9: The spare for entry i is spare i mod N_SPARE. Writes to a remapped entry land in its spare.
- R10: After reset, `rsp_valid` is 0, `lk_ready` is 1, no entry is remapped, and every register holds the all-zero codeword (a lookup returns path 0 with `err_type` 00).
- R11: `flt_mask` affects only primary-register reads. With the mask at zero, every primary read is clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Transaction address; only the upper TAG_W bits are used |
| lk_ready | output | 1 | High in IDLE; lookups are accepted only then |
| wr_en | input | 1 | Path write strobe |
| wr_idx | input | IDX_W | Entry to write |
| wr_path | input | PATH_W | Path value to encode and store |
| flt_mask | input | CW_W | Fault emulation XOR mask on primary reads |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | A region matched |
| rsp_path | output | PATH_W | Corrected routing path |
| err_type | output | 2 | 00 none, 01 single corrected, 10 double |
| err_idx | output | IDX_W | Entry index of the result |
| err_spare | output | 1 | Result read from a spare register |

## Verification
The assertions assume three things about the inputs:
- Writes arrive only while `lk_ready` is high.
- `flt_mask` never carries more than two set bits, so the decoder's single and double classes are exact.
- Two remapped entries never share a spare.

The stimulus writes only in IDLE, uses masks with one or two bits set, and remaps a single entry. The mask is changed only between lookups, either held through a repair or cleared during WBACK, so the transient and permanent outcomes are each decided by one known read.

// File: rtl/lut_pkg.sv
package lut_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WBACK,
        ST_RECHK,
        ST_REMAP
    } fix_state_e;

    localparam logic [1:0] ERR_NONE   = 2'b00;
    localparam logic [1:0] ERR_SINGLE = 2'b01;
    localparam logic [1:0] ERR_DOUBLE = 2'b10;

    // Path length for a square mesh of side m: three bits per hop.
    function automatic int path_bits(int m);
        return 3 * (2 * m - 1);
    endfunction

    // Hamming bits r (smallest with 2^r >= d+r+1) plus one parity bit.
    function automatic int chk_bits(int d);
        for (int r = 1; r < 8; r++) begin
            if ((1 << r) >= d + r + 1) return r + 1;
        end
        return 8;
    endfunction

    // Column i of the odd-weight parity matrix: weight 3 first, then 5, 7.
    function automatic logic [7:0] hcol(int i, int c);
        int k;
        k = 0;
        for (int w = 3; w <= 7; w += 2) begin
            for (int v = 0; v < 256; v++) begin
                if (v < (1 << c) && $countones(8'(v)) == w) begin
                    if (k == i) return 8'(v);
                    k++;
                end
            end
        end
        return 8'h00;
    endfunction

endpackage

// File: rtl/lut_region_match.sv
module lut_region_match #(
    parameter int N_ENTRY     = 8,
    parameter int TAG_W       = 8,
    parameter int REGION_STEP = 16,
    localparam int IDX_W      = $clog2(N_ENTRY)
) (
    input  logic [TAG_W-1:0] tag,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [N_ENTRY-1:0] line_hit;

    generate
        for (genvar g = 0; g < N_ENTRY; g++) begin : g_line
            localparam logic [TAG_W:0] LO = (TAG_W+1)'(g * REGION_STEP);
            localparam logic [TAG_W:0] HI = (TAG_W+1)'((g + 1) * REGION_STEP);
            assign line_hit[g] = ({1'b0, tag} >= LO) && ({1'b0, tag} < HI);
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N_ENTRY - 1; i >= 0; i--) begin
            if (line_hit[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lut_secded_enc.sv
module lut_secded_enc import lut_pkg::*; #(
    parameter int D = 15,
    parameter int C = 6
) (
    input  logic [D-1:0]   data,
    output logic [D+C-1:0] cw
);
    logic [C-1:0] chk;
    logic [7:0]   col;

    always_comb begin
        chk = '0;
        col = '0;
        for (int i = 0; i < D; i++) begin
            col = hcol(i, C);
            if (data[i]) chk = chk ^ col[C-1:0];
        end
    end

    assign cw = {chk, data};
endmodule

// File: rtl/lut_secded_dec.sv
module lut_secded_dec import lut_pkg::*; #(
    parameter int D = 15,
    parameter int C = 6
) (
    input  logic [D+C-1:0] cw,
    output logic [D-1:0]   data,
    output logic           single,
    output logic           dbl
);
    logic [C-1:0] syn;
    logic [7:0]   col;
    logic         col_hit;

    always_comb begin
        syn     = cw[D+C-1:D];
        col     = '0;
        col_hit = 1'b0;
        data    = cw[D-1:0];
        for (int i = 0; i < D; i++) begin
            col = hcol(i, C);
            if (cw[i]) syn = syn ^ col[C-1:0];
        end
        for (int i = 0; i < D; i++) begin
            col = hcol(i, C);
            if (syn == col[C-1:0]) begin
                data[i] = ~cw[i];
                col_hit = 1'b1;
            end
        end
        single = (syn != '0) && (^syn) && (col_hit || $onehot(syn));
        dbl    = (syn != '0) && !single;
    end
endmodule

// File: rtl/route_lut.sv
module route_lut import lut_pkg::*; #(
    parameter int ADDR_W      = 32,
    parameter int TAG_W       = 8,
    parameter int N_ENTRY     = 8,
    parameter int N_SPARE     = 2,
    parameter int MESH_N      = 3,
    parameter int REGION_STEP = 16,
    localparam int PATH_W     = path_bits(MESH_N),
    localparam int CHK_W      = chk_bits(PATH_W),
    localparam int CW_W       = PATH_W + CHK_W,
    localparam int IDX_W      = $clog2(N_ENTRY),
    localparam int SP_W       = $clog2(N_SPARE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_ready,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PATH_W-1:0] wr_path,
    input  logic [CW_W-1:0]   flt_mask,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PATH_W-1:0] rsp_path,
    output logic [1:0]        err_type,
    output logic [IDX_W-1:0]  err_idx,
    output logic              err_spare
);
    fix_state_e state_q, state_d;

    logic [CW_W-1:0]    prim_q  [N_ENTRY];
    logic [CW_W-1:0]    spare_q [N_SPARE];
    logic [N_ENTRY-1:0] use_spare_q;
    logic [IDX_W-1:0]   fix_idx_q;
    logic [PATH_W-1:0]  fix_data_q;

    logic               m_hit;
    logic [IDX_W-1:0]   m_idx;
    logic [IDX_W-1:0]   rd_idx;
    logic               rd_spare;
    logic [CW_W-1:0]    rd_word;
    logic [PATH_W-1:0]  dec_data;
    logic               dec_single;
    logic               dec_dbl;
    logic [PATH_W-1:0]  enc_in;
    logic [CW_W-1:0]    enc_cw;
    logic               lk_take;
    logic               unused_addr_lo;

    assign unused_addr_lo = ^lk_addr[ADDR_W-TAG_W-1:0];

    lut_region_match #(
        .N_ENTRY(N_ENTRY), .TAG_W(TAG_W), .REGION_STEP(REGION_STEP)
    ) u_match (
        .tag(lk_addr[ADDR_W-1 -: TAG_W]), .hit(m_hit), .idx(m_idx)
    );

    // One read port: the repair re-read borrows it in RECHK.
    assign rd_idx   = (state_q == ST_RECHK) ? fix_idx_q : m_idx;
    assign rd_spare = use_spare_q[rd_idx];
    assign rd_word  = rd_spare ? spare_q[rd_idx[SP_W-1:0]]
                               : (prim_q[rd_idx] ^ flt_mask);

    lut_secded_dec #(.D(PATH_W), .C(CHK_W)) u_dec (
        .cw(rd_word), .data(dec_data), .single(dec_single), .dbl(dec_dbl)
    );

    assign enc_in = (state_q == ST_IDLE) ? wr_path : fix_data_q;

    lut_secded_enc #(.D(PATH_W), .C(CHK_W)) u_enc (
        .data(enc_in), .cw(enc_cw)
    );

    assign lk_ready = (state_q == ST_IDLE);
    assign lk_take  = lk_ready && lk_valid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (lk_take && m_hit && dec_single) state_d = ST_WBACK;
            ST_WBACK: state_d = ST_RECHK;
            ST_RECHK: state_d = (dec_single && !rd_spare) ? ST_REMAP : ST_IDLE;
            ST_REMAP: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Storage, repair bookkeeping and registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRY; i++) prim_q[i] <= '0;
            for (int i = 0; i < N_SPARE; i++) spare_q[i] <= '0;
            use_spare_q <= '0;
            fix_idx_q   <= '0;
            fix_data_q  <= '0;
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_path    <= '0;
            err_type    <= ERR_NONE;
            err_idx     <= '0;
            err_spare   <= 1'b0;
        end else begin
            rsp_valid <= lk_take;
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_en) begin
                        if (use_spare_q[wr_idx]) spare_q[wr_idx[SP_W-1:0]] <= enc_cw;
                        else                     prim_q[wr_idx] <= enc_cw;
                    end
                    if (lk_take) begin
                        fix_idx_q  <= m_idx;
                        fix_data_q <= dec_data;
                        rsp_hit    <= m_hit;
                        err_idx    <= m_hit ? m_idx : '0;
                        err_spare  <= m_hit && rd_spare;
                        rsp_path   <= (m_hit && !dec_dbl) ? dec_data : '0;
                        if (!m_hit)          err_type <= ERR_NONE;
                        else if (dec_dbl)    err_type <= ERR_DOUBLE;
                        else if (dec_single) err_type <= ERR_SINGLE;
                        else                 err_type <= ERR_NONE;
                    end
                end
                ST_WBACK: begin
                    if (use_spare_q[fix_idx_q]) spare_q[fix_idx_q[SP_W-1:0]] <= enc_cw;
                    else                        prim_q[fix_idx_q] <= enc_cw;
                end
                ST_RECHK: begin
                end
                ST_REMAP: begin
                    use_spare_q[fix_idx_q]       <= 1'b1;
                    spare_q[fix_idx_q[SP_W-1:0]] <= enc_cw;
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/route_lut_chk.sv
module route_lut_chk import lut_pkg::*; #(
    parameter int PATH_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [PATH_W-1:0] rsp_path,
    input logic [1:0]        err_type,
    input fix_state_e        state_q
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && lk_ready) |=> !rsp_valid); // R2
    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_path == '0 && err_type == ERR_NONE)); // R3
    AST_ERR_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        err_type != 2'b11); // R6
    AST_DOUBLE_NO_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && err_type == ERR_DOUBLE) |-> (rsp_path == '0 && lk_ready)); // R6
    AST_SINGLE_STARTS_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && err_type == ERR_SINGLE) |-> !lk_ready); // R7
    AST_REPAIR_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lk_ready) |=> !lk_ready); // R7
    AST_REMAP_AFTER_RECHK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REMAP) |-> ($past(state_q) == ST_RECHK)); // R8
endmodule

bind route_lut route_lut_chk #(.PATH_W(PATH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_path(rsp_path),
    .err_type(err_type), .state_q(state_q)
);

// File: tb/route_lut_test.sv
module route_lut_test;
    localparam int PW = 15;
    localparam int CW = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [31:0]   lk_addr = '0;
    logic          lk_ready;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_idx = '0;
    logic [PW-1:0] wr_path = '0;
    logic [CW-1:0] flt_mask = '0;
    logic          rsp_valid, rsp_hit, err_spare;
    logic [PW-1:0] rsp_path;
    logic [1:0]    err_type;
    logic [2:0]    err_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    route_lut uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_ready(lk_ready), .wr_en(wr_en), .wr_idx(wr_idx), .wr_path(wr_path),
        .flt_mask(flt_mask), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_path(rsp_path), .err_type(err_type), .err_idx(err_idx),
        .err_spare(err_spare)
    );

    // {tag, expected hit, expected entry}
    localparam logic [11:0] VEC [11] = '{
        {8'h00, 1'b1, 3'd0}, {8'h0F, 1'b1, 3'd0}, {8'h10, 1'b1, 3'd1},
        {8'h2A, 1'b1, 3'd2}, {8'h3F, 1'b1, 3'd3}, {8'h40, 1'b1, 3'd4},
        {8'h5C, 1'b1, 3'd5}, {8'h6B, 1'b1, 3'd6}, {8'h7F, 1'b1, 3'd7},
        {8'h80, 1'b0, 3'd0}, {8'hFF, 1'b0, 3'd0}
    };

    function automatic logic [PW-1:0] pv(int i);
        return PW'(i * 2989 + 4660);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_path(int idx, logic [PW-1:0] p);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_path = p;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Result is registered at the posedge between the two negedges.
    task automatic lookup(logic [7:0] tag);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = {tag, 24'h00ABCD};
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_rsp(string req, logic h, int idx, logic [PW-1:0] p,
                              logic [1:0] e, logic sp);
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " hit"},   32'(rsp_hit),   32'(h));
        check({req, " path"},  32'(rsp_path),  32'(p));
        check({req, " err"},   32'(err_type),  32'(e));
        check({req, " idx"},   32'(err_idx),   32'(idx));
        check({req, " spare"}, 32'(err_spare), 32'(sp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        check("R10 ready in reset", 32'(lk_ready), 32'd1);
        rst_n = 1'b1;
        lookup(8'h20);
        expect_rsp("R10 zero word after reset", 1'b1, 2, '0, 2'b00, 1'b0);
        @(negedge clk);
        check("R2 no response without request", 32'(rsp_valid), 32'd0);

        for (int i = 0; i < 8; i++) write_path(i, pv(i));

        // R1 R3 R4: region table walk
        foreach (VEC[k]) begin
            lookup(VEC[k][11:4]);
            if (VEC[k][3])
                expect_rsp("R1 R4 region hit", 1'b1, int'(VEC[k][2:0]),
                           pv(int'(VEC[k][2:0])), 2'b00, 1'b0);
            else
                expect_rsp("R3 miss", 1'b0, 0, '0, 2'b00, 1'b0);
        end

        // R5 R7: transient single error in entry 2
        flt_mask = CW'(1) << 4;
        lookup(8'h21);
        expect_rsp("R5 single corrected", 1'b1, 2, pv(2), 2'b01, 1'b0);
        check("R7 busy WBACK", 32'(lk_ready), 32'd0);
        flt_mask = '0;
        @(negedge clk);
        check("R7 busy RECHK", 32'(lk_ready), 32'd0);
        @(negedge clk);
        check("R7 ready after transient", 32'(lk_ready), 32'd1);
        lookup(8'h22);
        expect_rsp("R7 R11 primary clean after rewrite", 1'b1, 2, pv(2), 2'b00, 1'b0);

        // R6: double error in entry 3 (two check bits)
        flt_mask = CW'(3) << 16;
        lookup(8'h33);
        expect_rsp("R6 double detected", 1'b1, 3, '0, 2'b10, 1'b0);
        check("R6 no repair", 32'(lk_ready), 32'd1);
        flt_mask = '0;

        // R8: permanent single error in entry 5 (mask held)
        flt_mask = CW'(1) << 2;
        lookup(8'h55);
        expect_rsp("R8 single before remap", 1'b1, 5, pv(5), 2'b01, 1'b0);
        check("R8 busy WBACK", 32'(lk_ready), 32'd0);
        @(negedge clk);
        check("R8 busy RECHK", 32'(lk_ready), 32'd0);
        @(negedge clk);
        check("R8 busy REMAP", 32'(lk_ready), 32'd0);
        @(negedge clk);
        check("R8 ready after remap", 32'(lk_ready), 32'd1);
        lookup(8'h50);
        expect_rsp("R8 served by spare", 1'b1, 5, pv(5), 2'b00, 1'b1);

        // R9: writes to remapped entry land in spare 5 mod 2
        write_path(5, 15'h6A5C);
        lookup(8'h5F);
        expect_rsp("R9 spare write", 1'b1, 5, 15'h6A5C, 2'b00, 1'b1);

        // R11: mask cleared, other primaries clean
        flt_mask = '0;
        lookup(8'h11);
        expect_rsp("R11 primary clean", 1'b1, 1, pv(1), 2'b00, 1'b0);
        lookup(8'h77);
        expect_rsp("R11 R4 entry 7 intact", 1'b1, 7, pv(7), 2'b00, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule